// File: doc/BRIEF.md
# Split-Transaction Memory Request Port

This block sits between a requestor and a memory back end and decouples the acceptance of a command from the return of read data. The requestor presents a command (address, a write flag and, for writes, the write data) with a request strobe. The block takes it on any cycle where its hold-off output is low and stores it in an internal command queue. Because a read counts as done once it is accepted, the requestor can issue further reads and writes straight away, and several reads can be waiting for their data at the same time.

The back end is modelled as a word memory that takes one command per cycle from the head of the queue. It returns each read through a pipeline of fixed length. A stall input, standing for refresh or page-change work, stops the back end from taking commands. The queue then fills and the hold-off output stays raised. Read data comes back strictly in acceptance order, one valid cycle per read. A counter of reads still owed keeps the number of outstanding reads within the queue depth.

Top module: `sxn_req_port`

## Requirements
- R1: A command transfers only on a rising clock edge where `req_valid` is 1 and `req_wait` is 0; a command offered while `req_wait` is 1 has no effect, so a write offered then leaves memory unchanged.
- R2: A write (`req_write` = 1) carries its address and data in its single transfer cycle, and any read accepted after it to that address returns that data.
- R3: Every accepted read (`req_write` = 0) produces exactly one cycle with `rd_valid` = 1, no sooner than LATENCY (default 4) cycles after its transfer cycle, and `rd_valid` is never raised without a read outstanding.
- R4: Read data returns on `rd_data` in the order the reads were accepted.
- R5: With `mem_stall` low, the requestor can issue commands on consecutive cycles: a burst of back-to-back reads or writes is accepted one per cycle without `req_wait` rising.
- R6: While `mem_stall` is 1, exactly DEPTH (default 8) commands are accepted into an empty queue, after which `req_wait` stays 1 for as long as the stall lasts.
- R7: The number of accepted reads whose data has not yet returned never exceeds DEPTH, and `req_wait` is 1 whenever that number equals DEPTH, even after the queue has begun to drain.
- R8: While `mem_stall` is 1, the back end takes no command from the queue, so once earlier reads have returned, `rd_valid` stays 0.
- R9: Reset (`rst_n` low, asynchronous) empties the queue and discards outstanding reads: `req_wait` and `rd_valid` are 0 during and after reset, and no discarded read ever returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Requestor offers a command this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (4) | Word address |
| req_wdata | input | DW (16) | Write data, used when `req_write` is 1 |
| req_wait | output | 1 | Hold-off: the command is not taken this cycle |
| mem_stall | input | 1 | Back end busy; no command leaves the queue |
| rd_valid | output | 1 | One cycle per returned read |
| rd_data | output | DW (16) | Returned read data, valid with `rd_valid` |

## Verification
The first pattern is a write sweep over every address followed by a read sweep, both back to back with no stall. It separates correct per-cycle acceptance and ordering from designs that insert dead cycles or reorder returns. A stalled burst of reads, with a write offered while held off, shows whether the queue-full hold-off, the ignore rule and the outstanding-read limit work after the stall lifts. Here the queue drains while the reads are still owed, which is the case that tells the read counter apart from a queue-only hold-off. A reset taken with reads in flight, and a long run of randomly mixed reads, writes and stalls checked against a memory model, show whether hazards between reads and writes are ordered correctly.

// File: rtl/sxn_pkg.sv
package sxn_pkg;

  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } sxn_op_e;

endpackage

// File: rtl/sxn_cmd_queue.sv
module sxn_cmd_queue #(
  parameter int W     = 21,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_P = PW'(DEPTH-1);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full  = (cnt_q == FULL_C);
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign head  = slot[rd_ptr_q];

  // next state
  always_comb begin
    do_push  = push && !full;
    do_pop   = pop && !empty;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = (wr_ptr_q == LAST_P) ? '0 : wr_ptr_q + PW'(1);
    if (do_pop)  rd_ptr_d = (rd_ptr_q == LAST_P) ? '0 : rd_ptr_q + PW'(1);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage, clock-enabled, not reset
  always_ff @(posedge clk) begin
    if (do_push) slot[wr_ptr_q] <= din;
  end

endmodule

// File: rtl/sxn_mem_model.sv
module sxn_mem_model #(
  parameter int AW      = 4,
  parameter int DW      = 16,
  parameter int LATENCY = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          is_wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ret_valid,
  output logic [DW-1:0] ret_data
);

  localparam int NWORD = 1 << AW;

  logic [DW-1:0] mem [NWORD];
  logic          stg_v [LATENCY];
  logic [DW-1:0] stg_d [LATENCY];
  logic          rd_issue;
  logic          wr_issue;

  assign rd_issue = issue && !is_wr;
  assign wr_issue = issue && is_wr;

  always_ff @(posedge clk) begin
    if (wr_issue) mem[addr] <= wdata;
  end

  // first pipeline stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_v[0] <= 1'b0;
    else        stg_v[0] <= rd_issue;
  end

  always_ff @(posedge clk) begin
    if (rd_issue) stg_d[0] <= mem[addr];
  end

  // remaining stages
  for (genvar g = 1; g < LATENCY; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_v[g] <= 1'b0;
      else        stg_v[g] <= stg_v[g-1];
    end
    always_ff @(posedge clk) begin
      if (stg_v[g-1]) stg_d[g] <= stg_d[g-1];
    end
  end

  assign ret_valid = stg_v[LATENCY-1];
  assign ret_data  = stg_d[LATENCY-1];

endmodule

// File: rtl/sxn_rd_tracker.sv
module sxn_rd_tracker #(
  parameter int LIMIT = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take,
  input  logic                        give,
  output logic [$clog2(LIMIT+1)-1:0]  cnt,
  output logic                        at_limit
);

  localparam int CW = $clog2(LIMIT+1);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    case ({take, give})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt      = cnt_q;
  assign at_limit = (cnt_q == LIM_C);

endmodule

// File: rtl/sxn_req_port.sv
module sxn_req_port
  import sxn_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DW      = 16,
  parameter int DEPTH   = 8,
  parameter int LATENCY = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_wait,
  input  logic          mem_stall,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  localparam int CMD_W = 1 + AW + DW;
  localparam int CNT_W = $clog2(DEPTH+1);

  typedef struct packed {
    sxn_op_e       op;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } cmd_t;

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  cmd_t             in_cmd, head_cmd;
  logic [CMD_W-1:0] head_bits;
  logic             q_full, q_empty;
  logic [CNT_W-1:0] q_cnt;
  logic [CNT_W-1:0] rd_cnt;
  logic             rd_at_limit;
  logic             accept, rd_take, pop;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign in_cmd   = '{op: sxn_op_e'(req_write), addr: req_addr, data: req_wdata};
  assign req_wait = q_full || rd_at_limit;
  assign accept   = req_valid && !req_wait;
  assign rd_take  = accept && (in_cmd.op == OP_RD);
  assign pop      = !q_empty && !mem_stall;
  assign head_cmd = cmd_t'(head_bits);

  sxn_cmd_queue #(.W(CMD_W), .DEPTH(DEPTH)) queue_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (accept),
    .din   (in_cmd),
    .pop   (pop),
    .head  (head_bits),
    .full  (q_full),
    .empty (q_empty),
    .count (q_cnt)
  );

  sxn_mem_model #(.AW(AW), .DW(DW), .LATENCY(LATENCY)) mem_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .issue     (pop),
    .is_wr     (head_cmd.op == OP_WR),
    .addr      (head_cmd.addr),
    .wdata     (head_cmd.data),
    .ret_valid (rd_valid),
    .ret_data  (rd_data)
  );

  sxn_rd_tracker #(.LIMIT(DEPTH)) track_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .take     (rd_take),
    .give     (rd_valid),
    .cnt      (rd_cnt),
    .at_limit (rd_at_limit)
  );

endmodule

// File: rtl/sxn_req_port_chk.sv
module sxn_req_port_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_wait,
  input logic          mem_stall,
  input logic          rd_valid,
  input logic [CW-1:0] q_cnt,
  input logic [CW-1:0] rd_cnt
);

  localparam logic [CW-1:0] TOP_C = CW'(DEPTH);

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= TOP_C);

  assert_hold_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_wait |=> rd_cnt <= $past(rd_cnt));

  assert_ret_owed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_cnt != '0);

  assert_full_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt == TOP_C) |-> req_wait);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stall |=> q_cnt >= $past(q_cnt));

endmodule

bind sxn_req_port sxn_req_port_chk #(.DEPTH(DEPTH), .CW(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_wait  (req_wait),
  .mem_stall (mem_stall),
  .rd_valid  (rd_valid),
  .q_cnt     (q_cnt),
  .rd_cnt    (rd_cnt)
);

// File: tb/sxn_req_port_tb_top.sv
module sxn_req_port_tb_top;

  localparam int AW = 4, DW = 16, DEPTH = 8, LAT = 4;
  localparam time CLK_P = 20ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write, mem_stall;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_wait, rd_valid;
  logic [DW-1:0] rd_data;

  always #(CLK_P/2) clk = ~clk;

  sxn_req_port #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .LATENCY(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wait(req_wait),
    .mem_stall(mem_stall), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, out_cnt = 0, acc_cnt = 0;
  logic          last_acc;
  logic [DW-1:0] last_rd;
  logic [DW-1:0] mem_m [1<<AW];
  logic [DW-1:0] exp_d [$];
  int            exp_c [$];

  function automatic logic [DW-1:0] seed_val(int a);
    return DW'(a * 16'h0111 + 7);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // one cycle: drive at negedge, observe, book-keep, move to next negedge
  task automatic step(input logic v, input logic w, input int a, input int d, input logic s);
    req_valid = v; req_write = w; req_addr = AW'(a); req_wdata = DW'(d); mem_stall = s;
    #1;
    if (out_cnt == DEPTH) chk(req_wait == 1'b1, "R7 wait at read limit", req_wait, 1);
    if (out_cnt > DEPTH) chk(1'b0, "R7 outstanding bound", out_cnt, DEPTH);
    if (rd_valid) begin
      last_rd = rd_data;
      if (exp_d.size() == 0) chk(1'b0, "R3 return with nothing owed", rd_data, 0);
      else begin
        chk(rd_data == exp_d[0], "R4 in-order read data", rd_data, exp_d[0]);
        chk(cyc - exp_c[0] >= LAT, "R3 return latency", cyc - exp_c[0], LAT);
        void'(exp_d.pop_front());
        void'(exp_c.pop_front());
      end
      out_cnt--;
    end
    last_acc = v && !req_wait;
    if (last_acc) begin
      acc_cnt++;
      if (w) mem_m[a] = DW'(d);
      else begin
        exp_d.push_back(mem_m[a]);
        exp_c.push_back(cyc);
        out_cnt++;
      end
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic s);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0, s);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int k;
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; mem_stall = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(req_wait == 1'b0, "R9 wait in reset", req_wait, 0);
    chk(rd_valid == 1'b0, "R9 rd_valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    idle(4, 1'b0);

    // R2 / R5: back-to-back write sweep
    acc_cnt = 0;
    for (int a = 0; a < (1 << AW); a++) step(1'b1, 1'b1, a, seed_val(a), 1'b0);
    chk(acc_cnt == (1 << AW), "R5 back-to-back writes accepted", acc_cnt, 1 << AW);
    // R2 / R4 / R5: back-to-back read sweep
    acc_cnt = 0;
    for (int a = 0; a < (1 << AW); a++) step(1'b1, 1'b0, a, 0, 1'b0);
    chk(acc_cnt == (1 << AW), "R5 back-to-back reads accepted", acc_cnt, 1 << AW);
    idle(LAT + 4, 1'b0);
    chk(exp_d.size() == 0, "R2 all sweep reads returned", exp_d.size(), 0);

    // R6 / R8: stalled burst of reads
    acc_cnt = 0;
    for (int a = 0; a < 12; a++) step(1'b1, 1'b0, a, 0, 1'b1);
    chk(acc_cnt == DEPTH, "R6 accepted under stall", acc_cnt, DEPTH);
    // R1: write offered while held off must be ignored
    for (int i = 0; i < 6; i++) begin
      chk(req_wait == 1'b1, "R6 wait held during stall", req_wait, 1);
      chk(rd_valid == 1'b0, "R8 no return during stall", rd_valid, 0);
      step(1'b1, 1'b1, 5, 16'hDEAD, 1'b1);
      chk(last_acc == 1'b0, "R1 held-off write not taken", last_acc, 0);
    end
    // release: queue drains while reads are still owed
    step(1'b0, 1'b0, 0, 0, 1'b0);
    chk(req_wait == 1'b1, "R7 wait after queue pop, reads owed", req_wait, 1);
    idle(LAT + DEPTH + 4, 1'b0);
    chk(out_cnt == 0, "R3 stalled reads all returned", out_cnt, 0);
    step(1'b1, 1'b0, 5, 0, 1'b0);
    idle(LAT + 3, 1'b0);
    chk(last_rd == seed_val(5), "R1 ignored write left memory", last_rd, seed_val(5));

    // R9: reset with reads in flight
    for (int a = 0; a < 6; a++) step(1'b1, 1'b0, a, 0, 1'b0);
    rst_n = 1'b0; req_valid = 0; mem_stall = 0;
    repeat (2) @(negedge clk);
    chk(req_wait == 1'b0, "R9 wait after reset", req_wait, 0);
    chk(rd_valid == 1'b0, "R9 rd_valid after reset", rd_valid, 0);
    exp_d.delete(); exp_c.delete(); out_cnt = 0;
    rst_n = 1'b1;
    for (int i = 0; i < LAT + 12; i++) begin
      chk(rd_valid == 1'b0, "R9 discarded read returned", rd_valid, 0);
      step(1'b0, 1'b0, 0, 0, 1'b0);
    end

    // constrained random traffic
    k = $urandom(32'd20240517);
    for (int i = 0; i < 3000; i++) begin
      logic v, w, s;
      v = ($urandom % 10) < 7;
      w = ($urandom % 10) < 4;
      s = ($urandom % 100) < 15;
      step(v, w, int'($urandom % (1 << AW)), int'($urandom % (1 << DW)), s);
    end
    idle(DEPTH + LAT + 10, 1'b0);
    chk(exp_d.size() == 0, "R3 every random read returned", exp_d.size(), 0);
    chk(out_cnt == 0, "R7 outstanding drained", out_cnt, 0);
    chk(req_wait == 1'b0, "R5 wait low when idle", req_wait, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule